// File: doc/BRIEF.md
# Chirp Sequencer with Mixer Interlock

This block converts chirp requests from a slow control clock domain into a transmit and listen sequence in a faster transmit clock domain. On the control side, `req_lvl` is a level signal. Every change of that level, rising or falling, asks for one chirp. The request passes through a synchronizer and an edge detector in the transmit domain. Each detected edge starts one sequence with three parts: a transmit window of `CHIRP_LEN` cycles, a single dead cycle with both mixers off, and a listen window of `LISTEN_LEN` cycles. A request that arrives while a sequence is running is held in a one-deep queue. It starts once the sequencer is idle again.

The transmit mixer is on only during the transmit window and the receive mixer only during the listen window. The RF switch, the chirp-active strobe for the waveform generator and all of the replicated beamformer T/R lines follow the transmit window. The control-side `mix_en_req` input is a hard interlock. When it is low, both mixers are forced off within a bounded number of control cycles, and the sequencer keeps running with its mixers silenced. A chirp counter in the transmit domain counts started chirps. It returns to the control domain as a Gray code through a synchronizer. The ADC power-down output is held low.

Top module: `chirp_seq_top`

## Requirements
- R1: Every change of `req_lvl`, in either direction, starts exactly one sequence, and `chirp_cnt_tx` increments by one (modulo 2^CNT_W) in the cycle `chirp_act` rises. At no other time does it change.
- R2: Requests that are each held for at least 4 control cycles and are spaced at least one full sequence apart are all delivered. For example, with the default lengths a spacing of 300 ns or more loses none.
- R3: One request arriving during a running sequence is queued and started after it. Any further request that arrives during that same sequence is dropped.
- R4: `tx_mix_en` and `rx_mix_en` are never both high in the same transmit-domain cycle.
- R5: A sequence holds `tx_mix_en` and `chirp_act` high for exactly `CHIRP_LEN` cycles. It then has exactly one cycle with both mixers low, then holds `rx_mix_en` high for exactly `LISTEN_LEN` cycles.
- R6: `rf_sw` and every bit of `tr_line` are 1 exactly while `chirp_act` is 1, and 0 otherwise. All T/R bits are always equal.
- R7: When `mix_en_req` is low, both mixer enables are low no later than 12 control cycles after it fell. Sequences and the counter keep advancing, and no mixer turns on until `mix_en_req` returns high.
- R8: `adc_pd` is 0 at all times.
- R9: `chirp_cnt_ctl` equals `chirp_cnt_tx`, including across the wrap from 2^CNT_W-1 to 0, once the counter has been stable for a few control cycles.
- R10: While `rst_n` is low, all mixer enables, `rf_sw`, `tr_line`, `chirp_act` and both counters are 0, including when reset is applied in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ctl | input | 1 | Control-domain clock |
| clk_tx | input | 1 | Transmit-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| req_lvl | input | 1 | Chirp request level (control domain); each change is one request |
| mix_en_req | input | 1 | Mixer permission (control domain); low forces both mixers off |
| tx_mix_en | output | 1 | Transmit mixer enable |
| rx_mix_en | output | 1 | Receive mixer enable |
| rf_sw | output | 1 | RF switch, high during the transmit window |
| tr_line | output | NUM_TR | Replicated beamformer T/R lines |
| chirp_act | output | 1 | Chirp-active strobe for the waveform generator |
| chirp_cnt_tx | output | CNT_W | Chirp counter, transmit domain |
| chirp_cnt_ctl | output | CNT_W | Chirp counter carried into the control domain |
| adc_pd | output | 1 | ADC power-down, tied low |

## Verification
The assertions assume three things about the inputs. Each level of `req_lvl` is held long enough for the transmit-domain synchronizer to capture it. `req_lvl` is low while reset is released, so the release cannot look like an edge. The counter advances no more than once per several control cycles, so a single Gray bit is in flight at a time. The stimulus meets all three. It changes `req_lvl` only at least five control cycles apart. It forces the level low before every reset, and it never shortens a sequence below a few dozen transmit cycles. Drop and queue behaviour is covered by deliberately packing three requests into one sequence.

// File: rtl/chirp_seq_pkg.sv
`timescale 1ns / 1ps
package chirp_seq_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_TX   = 2'd1,
      SQ_GAP  = 2'd2,
      SQ_RX   = 2'd3
   } seq_state_t;
endpackage

// File: rtl/cs_sync.sv
`timescale 1ns / 1ps
module cs_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/cs_gray_xfer.sv
`timescale 1ns / 1ps
module cs_gray_xfer #(
   parameter int WIDTH  = 6,
   parameter int STAGES = 2
) (
   input  logic             clk_src,
   input  logic             clk_dst,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] bin_src,
   output logic [WIDTH-1:0] bin_dst
);
   logic [WIDTH-1:0] gray_src, gray_dst, bin_dec;

   always_ff @(posedge clk_src or negedge rst_n) begin
      if (!rst_n) gray_src <= '0;
      else        gray_src <= bin_src ^ (bin_src >> 1);
   end

   cs_sync #(.WIDTH(WIDTH), .STAGES(STAGES)) u_gsync (
      .clk(clk_dst), .rst_n(rst_n), .d(gray_src), .q(gray_dst)
   );

   always_comb begin
      bin_dec[WIDTH-1] = gray_dst[WIDTH-1];
      for (int i = WIDTH - 2; i >= 0; i--) bin_dec[i] = bin_dec[i+1] ^ gray_dst[i];
   end

   always_ff @(posedge clk_dst or negedge rst_n) begin
      if (!rst_n) bin_dst <= '0;
      else        bin_dst <= bin_dec;
   end
endmodule

// File: rtl/cs_sequencer.sv
`timescale 1ns / 1ps
module cs_sequencer
   import chirp_seq_pkg::*;
#(
   parameter int CHIRP_LEN  = 16,
   parameter int LISTEN_LEN = 32,
   parameter int CNT_W      = 6,
   parameter int NUM_TR     = 4,
   parameter bit OUT_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_edge,
   input  logic              mix_ok,
   output logic              tx_mix,
   output logic              rx_mix,
   output logic              rf_on,
   output logic [NUM_TR-1:0] tr,
   output logic              act,
   output logic [CNT_W-1:0]  cnt
);
   localparam int TMAX = (CHIRP_LEN > LISTEN_LEN) ? CHIRP_LEN : LISTEN_LEN;
   localparam int TW   = $clog2(TMAX + 1);

   seq_state_t       st_q, st_d;
   logic [TW-1:0]    tmr_q, tmr_d;
   logic             pend_q, pend_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      st_d   = st_q;
      tmr_d  = tmr_q;
      cnt_d  = cnt_q;
      pend_d = pend_q | req_edge;
      unique case (st_q)
         SQ_IDLE: begin
            if (req_edge || pend_q) begin
               st_d   = SQ_TX;
               tmr_d  = TW'(CHIRP_LEN - 1);
               cnt_d  = cnt_q + CNT_W'(1);
               pend_d = pend_q & req_edge;
            end
         end
         SQ_TX: begin
            if (tmr_q == '0) st_d = SQ_GAP;
            else             tmr_d = tmr_q - TW'(1);
         end
         SQ_GAP: begin
            st_d  = SQ_RX;
            tmr_d = TW'(LISTEN_LEN - 1);
         end
         SQ_RX: begin
            if (tmr_q == '0) st_d = SQ_IDLE;
            else             tmr_d = tmr_q - TW'(1);
         end
         default: st_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         tmr_q  <= '0;
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         st_q   <= st_d;
         tmr_q  <= tmr_d;
         pend_q <= pend_d;
         cnt_q  <= cnt_d;
      end
   end

   assign cnt = cnt_q;

   if (OUT_REG) begin : g_out_reg
      logic tx_q, rx_q, on_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tx_q <= 1'b0;
            rx_q <= 1'b0;
            on_q <= 1'b0;
         end else begin
            tx_q <= (st_d == SQ_TX) && mix_ok;
            rx_q <= (st_d == SQ_RX) && mix_ok;
            on_q <= (st_d == SQ_TX);
         end
      end
      assign tx_mix = tx_q;
      assign rx_mix = rx_q;
      assign rf_on  = on_q;
   end else begin : g_out_comb
      assign tx_mix = (st_q == SQ_TX) && mix_ok;
      assign rx_mix = (st_q == SQ_RX) && mix_ok;
      assign rf_on  = (st_q == SQ_TX);
   end

   assign act = rf_on;
   assign tr  = {NUM_TR{rf_on}};
endmodule

// File: rtl/chirp_seq_top.sv
`timescale 1ns / 1ps
module chirp_seq_top #(
   parameter int CHIRP_LEN   = 16,
   parameter int LISTEN_LEN  = 32,
   parameter int CNT_W       = 6,
   parameter int NUM_TR      = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic              clk_ctl,
   input  logic              clk_tx,
   input  logic              rst_n,
   input  logic              req_lvl,
   input  logic              mix_en_req,
   output logic              tx_mix_en,
   output logic              rx_mix_en,
   output logic              rf_sw,
   output logic [NUM_TR-1:0] tr_line,
   output logic              chirp_act,
   output logic [CNT_W-1:0]  chirp_cnt_tx,
   output logic [CNT_W-1:0]  chirp_cnt_ctl,
   output logic              adc_pd
);
   if (CHIRP_LEN < 1)   begin : g_bad_chirp  $error("CHIRP_LEN must be at least 1"); end
   if (LISTEN_LEN < 1)  begin : g_bad_listen $error("LISTEN_LEN must be at least 1"); end
   if (CNT_W < 2)       begin : g_bad_cnt    $error("CNT_W must be at least 2"); end
   if (NUM_TR < 1)      begin : g_bad_tr     $error("NUM_TR must be at least 1"); end
   if (SYNC_STAGES < 2) begin : g_bad_sync   $error("SYNC_STAGES must be at least 2"); end

   logic req_s, req_prev, req_edge, mix_ok;

   cs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_req_sync (
      .clk(clk_tx), .rst_n(rst_n), .d(req_lvl), .q(req_s)
   );

   always_ff @(posedge clk_tx or negedge rst_n) begin
      if (!rst_n) req_prev <= 1'b0;
      else        req_prev <= req_s;
   end
   assign req_edge = req_s ^ req_prev;

   cs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_mix_sync (
      .clk(clk_tx), .rst_n(rst_n), .d(mix_en_req), .q(mix_ok)
   );

   cs_sequencer #(
      .CHIRP_LEN(CHIRP_LEN), .LISTEN_LEN(LISTEN_LEN), .CNT_W(CNT_W),
      .NUM_TR(NUM_TR), .OUT_REG(OUT_REG)
   ) u_seq (
      .clk(clk_tx), .rst_n(rst_n), .req_edge(req_edge), .mix_ok(mix_ok),
      .tx_mix(tx_mix_en), .rx_mix(rx_mix_en), .rf_on(rf_sw), .tr(tr_line),
      .act(chirp_act), .cnt(chirp_cnt_tx)
   );

   cs_gray_xfer #(.WIDTH(CNT_W), .STAGES(SYNC_STAGES)) u_cnt_xfer (
      .clk_src(clk_tx), .clk_dst(clk_ctl), .rst_n(rst_n),
      .bin_src(chirp_cnt_tx), .bin_dst(chirp_cnt_ctl)
   );

   assign adc_pd = 1'b0;
endmodule

// File: rtl/chirp_seq_chk.sv
`timescale 1ns / 1ps
module chirp_seq_chk #(
   parameter int CNT_W     = 6,
   parameter int NUM_TR    = 4,
   parameter int OFF_LIMIT = 12
) (
   input logic              clk_ctl,
   input logic              clk_tx,
   input logic              rst_n,
   input logic              mix_en_req,
   input logic              tx_mix_en,
   input logic              rx_mix_en,
   input logic              rf_sw,
   input logic [NUM_TR-1:0] tr_line,
   input logic              chirp_act,
   input logic [CNT_W-1:0]  chirp_cnt_tx
);
   localparam int OW = $clog2(OFF_LIMIT + 1);

   logic [OW-1:0] off_cnt;
   logic          rst_held = 1'b0;

   always_ff @(posedge clk_ctl or negedge rst_n) begin
      if (!rst_n)                   off_cnt <= '0;
      else if (mix_en_req)          off_cnt <= '0;
      else if (off_cnt < OW'(OFF_LIMIT)) off_cnt <= off_cnt + OW'(1);
   end

   always_ff @(posedge clk_tx) rst_held <= !rst_n;

   assert_mix_excl_R4: assert property (@(posedge clk_tx) disable iff (!rst_n)
      !(tx_mix_en && rx_mix_en));

   assert_break_make_R5: assert property (@(posedge clk_tx) disable iff (!rst_n)
      $rose(rx_mix_en) |-> !$past(tx_mix_en));

   assert_tx_rf_R6: assert property (@(posedge clk_tx) disable iff (!rst_n)
      tx_mix_en |-> (rf_sw && (tr_line == {NUM_TR{1'b1}})));

   assert_cnt_step_R1: assert property (@(posedge clk_tx) disable iff (!rst_n)
      $rose(chirp_act) |-> (chirp_cnt_tx == $past(chirp_cnt_tx) + CNT_W'(1)));

   assert_cnt_hold_R1: assert property (@(posedge clk_tx) disable iff (!rst_n)
      !$rose(chirp_act) |-> $stable(chirp_cnt_tx));

   assert_mix_off_R7: assert property (@(posedge clk_ctl) disable iff (!rst_n)
      (off_cnt >= OW'(OFF_LIMIT)) |-> (!tx_mix_en && !rx_mix_en));

   assert_reset_quiet_R10: assert property (@(posedge clk_tx)
      (rst_held && !rst_n) |-> (!tx_mix_en && !rx_mix_en && !chirp_act && chirp_cnt_tx == '0));
endmodule

bind chirp_seq_top chirp_seq_chk #(.CNT_W(CNT_W), .NUM_TR(NUM_TR), .OFF_LIMIT(12)) u_chk (
   .clk_ctl(clk_ctl), .clk_tx(clk_tx), .rst_n(rst_n), .mix_en_req(mix_en_req),
   .tx_mix_en(tx_mix_en), .rx_mix_en(rx_mix_en), .rf_sw(rf_sw), .tr_line(tr_line),
   .chirp_act(chirp_act), .chirp_cnt_tx(chirp_cnt_tx)
);

// File: tb/chirp_seq_top_bench.sv
`timescale 1ns / 1ps
module chirp_seq_top_bench;
   localparam int CL = 16;
   localparam int LL = 32;
   localparam int CW = 4;
   localparam int NT = 4;
   localparam int MODV = 1 << CW;

   logic clk_tx = 1'b0;
   logic clk_ctl = 1'b0;
   logic rst_n = 1'b0;
   logic req_lvl = 1'b0;
   logic mix_en_req = 1'b0;
   logic tx_mix_en, rx_mix_en, rf_sw, chirp_act, adc_pd;
   logic [NT-1:0] tr_line;
   logic [CW-1:0] chirp_cnt_tx, chirp_cnt_ctl;

   always #2.5 clk_tx = ~clk_tx;
   always #4.0 clk_ctl = ~clk_ctl;

   chirp_seq_top #(.CHIRP_LEN(CL), .LISTEN_LEN(LL), .CNT_W(CW), .NUM_TR(NT)) u_chirp_seq_top (
      .clk_ctl(clk_ctl), .clk_tx(clk_tx), .rst_n(rst_n), .req_lvl(req_lvl),
      .mix_en_req(mix_en_req), .tx_mix_en(tx_mix_en), .rx_mix_en(rx_mix_en),
      .rf_sw(rf_sw), .tr_line(tr_line), .chirp_act(chirp_act),
      .chirp_cnt_tx(chirp_cnt_tx), .chirp_cnt_ctl(chirp_cnt_ctl), .adc_pd(adc_pd)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int exp_n = 0;
   bit done = 1'b0;
   bit pd_seen = 1'b0;

   always @(negedge clk_tx) if (adc_pd !== 1'b0) pd_seen = 1'b1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   task automatic flip_req();
      @(posedge clk_ctl); #1 req_lvl = ~req_lvl;
   endtask

   task automatic ctl_wait(input int n);
      repeat (n) @(posedge clk_ctl);
   endtask

   task automatic check_counts(input string req);
      ctl_wait(20);
      @(negedge clk_ctl);
      chk(int'(chirp_cnt_tx) == exp_n % MODV, req, int'(chirp_cnt_tx), exp_n % MODV);
      chk(int'(chirp_cnt_ctl) == exp_n % MODV, "R9", int'(chirp_cnt_ctl), exp_n % MODV);
   endtask

   initial begin
      #200000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      finish_run();
   end

   initial begin
      int t_len, g_len, r_len, lat, bad_tx, bad_rx, hot;
      // R10: reset state
      ctl_wait(4);
      @(negedge clk_tx);
      chk({tx_mix_en, rx_mix_en, rf_sw, chirp_act} == 4'b0, "R10", int'({tx_mix_en, rx_mix_en, rf_sw, chirp_act}), 0);
      chk(tr_line == '0 && chirp_cnt_tx == '0 && chirp_cnt_ctl == '0, "R10", int'(chirp_cnt_ctl), 0);
      #1 rst_n = 1'b1;
      mix_en_req = 1'b1;
      ctl_wait(10);

      // R5 / R6: shape of one sequence (rising request edge)
      flip_req();
      exp_n++;
      t_len = 0; g_len = 0; r_len = 0; bad_tx = 0; bad_rx = 0;
      for (int k = 0; k < 200 && !chirp_act; k++) @(negedge clk_tx);
      while (chirp_act) begin
         if (!(tx_mix_en && rf_sw && tr_line == {NT{1'b1}} && !rx_mix_en)) bad_tx++;
         t_len++;
         @(negedge clk_tx);
      end
      while (!rx_mix_en && g_len < 10) begin
         if (tx_mix_en || rf_sw || tr_line != '0) bad_rx++;
         g_len++;
         @(negedge clk_tx);
      end
      while (rx_mix_en) begin
         if (tx_mix_en || rf_sw || tr_line != '0 || chirp_act) bad_rx++;
         r_len++;
         @(negedge clk_tx);
      end
      chk(t_len == CL, "R5", t_len, CL);
      chk(g_len == 1, "R5", g_len, 1);
      chk(r_len == LL, "R5", r_len, LL);
      chk(bad_tx == 0, "R6", bad_tx, 0);
      chk(bad_rx == 0, "R6", bad_rx, 0);
      check_counts("R1");

      // R1: falling request edge also starts one sequence
      flip_req();
      exp_n++;
      #600;
      check_counts("R1");

      // R2 / R9: spacing sweep, counter wraps past 2^CW
      for (int sp = 0; sp < 3; sp++) begin
         for (int k = 0; k < 8; k++) begin
            flip_req();
            exp_n++;
            #(500 - sp * 100);
         end
         #600;
         check_counts("R2");
      end

      // R3: three requests in one sequence -> one runs, one queued, one dropped
      flip_req(); ctl_wait(5);
      flip_req(); ctl_wait(5);
      flip_req();
      exp_n += 2;
      #1500;
      check_counts("R3");

      // R7: drop mixer permission mid-transmit
      flip_req();
      exp_n++;
      for (int k = 0; k < 200 && !tx_mix_en; k++) @(negedge clk_tx);
      @(posedge clk_ctl); #1 mix_en_req = 1'b0;
      lat = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk_ctl);
         lat++;
         if (!tx_mix_en && !rx_mix_en) break;
      end
      chk(lat <= 12, "R7", lat, 12);
      hot = 0;
      for (int k = 0; k < 150; k++) begin
         @(negedge clk_tx);
         if (tx_mix_en || rx_mix_en) hot++;
      end
      chk(hot == 0, "R7", hot, 0);
      check_counts("R7");
      mix_en_req = 1'b1;

      // R10: reset in the middle of a sequence
      flip_req();
      for (int k = 0; k < 200 && !chirp_act; k++) @(negedge clk_tx);
      #1 rst_n = 1'b0;
      req_lvl = 1'b0;
      exp_n = 0;
      ctl_wait(4);
      @(negedge clk_ctl);
      chk({tx_mix_en, rx_mix_en, rf_sw, chirp_act} == 4'b0 && tr_line == '0, "R10",
          int'({tx_mix_en, rx_mix_en, rf_sw, chirp_act}), 0);
      chk(chirp_cnt_tx == '0 && chirp_cnt_ctl == '0, "R10", int'(chirp_cnt_ctl), 0);
      #1 rst_n = 1'b1;
      ctl_wait(10);
      flip_req();
      exp_n++;
      #600;
      check_counts("R1");

      // R8
      chk(!pd_seen, "R8", int'(pd_seen), 0);
      finish_run();
   end
endmodule